// File: doc/BRIEF.md
# Serial Display Command/Data Transmitter

This block sends bytes to a character or graphic display controller over four outgoing wires: an active-low chip select, a register-select line, a serial clock and a serial data line. The host offers one byte at a time with a valid/ready handshake. Each byte is tagged as a command or as data, and data bytes carry a flag that marks the last byte of a burst.

Every byte is framed as its own transfer. Chip select and the clock drop together. The eight bits then follow, most significant first, and each bit changes only while the clock is low. The register-select level that the display samples on the eighth rising clock edge tells an instruction from data. After the eighth bit all four wires return high.

The clock half-period is a whole number of system cycles, set by a parameter. A one-cycle done pulse closes each request: a command, or the last byte of a data burst.

Top module: `disp_ser_tx`

## Requirements
- R1: While reset (synchronous, active high) is sampled high, the next cycle shows `cs_n`, `reg_sel`, `sclk` and `sdo` all at 1, `in_ready` at 1 and `done` at 0.
- R2: Each transfer carries exactly eight bits on `sdo`, sampled at the rising edges of `sclk`, most significant bit first.
- R3: While `cs_n` is low, `sdo` never changes during a cycle in which `sclk` stays high.
- R4: At the eighth rising edge of `sclk` in a transfer, `reg_sel` is 0 for a command byte (`in_is_data`=0) and 1 for a data byte (`in_is_data`=1).
- R5: Whenever `cs_n` is high, `reg_sel`, `sclk` and `sdo` are all high.
- R6: Between two transfers `cs_n` stays high for at least HALF_CYC+1 system cycles.
- R7: `cs_n` and `sclk` fall in the same cycle. `sdo` then stays high for HALF_CYC cycles before the first bit appears.
- R8: Counting from the cycle in which `cs_n` falls (count 0), rising edge i of `sclk` (i = 0 to 7) appears at count 2·HALF_CYC·(i+1). The clock falls HALF_CYC cycles after each of the first seven rises. `cs_n` rises at count 17·HALF_CYC.
- R9: A byte is taken in a cycle in which `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the lines are idle again.
- R10: `done` pulses high for exactly one cycle, together with `in_ready`, when the lines are back to idle after a command byte or after a data byte with `in_last`=1. `in_last` is ignored for command bytes. No pulse follows a data byte with `in_last`=0.
- R11: A reset in the middle of a transfer returns all four lines to idle in the next cycle and drops the byte, and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | DW | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Last data byte of a burst |
| done | output | 1 | One-cycle end-of-request pulse |
| cs_n | output | 1 | Chip select, active low |
| reg_sel | output | 1 | Register select: 0 instruction, 1 data |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data, idle high |

## Verification
The assertions check the following on every cycle:
- the idle levels of the lines around chip select;
- that the data holds while the clock is high;
- that chip select and the clock fall together;
- the busy handshake;
- the shape of the done pulse.

Only the bench's scenarios can show the following:
- the bit order and the byte value, recovered from the wire;
- the register-select level at the eighth edge;
- the exact cycle of every clock edge;
- the idle gap between bytes;
- the number of done pulses across command sweeps and data bursts;
- that a byte dropped by a reset mid-transfer leaves no trace.

// File: rtl/disp_ser_tx.sv
module disp_ser_tx #(
  parameter int HALF_CYC = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_byte,
  input  logic          in_is_data,
  input  logic          in_last,
  output logic          done,
  output logic          cs_n,
  output logic          reg_sel,
  output logic          sclk,
  output logic          sdo
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_TAIL} st_t;

  st_t st;
  logic [CW-1:0] div;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic rs_q, last_q;
  logic half_end;

  assign half_end = (div == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      div    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rs_q   <= 1'b0;
      last_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        div <= '0;
        if (in_valid) begin
          sh     <= in_byte;
          rs_q   <= in_is_data;
          last_q <= !in_is_data || in_last;
          bitn   <= BW'(DW - 1);
          st     <= S_SETUP;
        end
      end else if (!half_end) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        case (st)
          S_SETUP: st <= S_LOW;
          S_LOW:   st <= S_HIGH;
          S_HIGH:
            if (bitn == '0) st <= S_TAIL;
            else begin
              bitn <= bitn - 1'b1;
              sh   <= {sh[DW-2:0], 1'b0};
              st   <= S_LOW;
            end
          default: begin
            st   <= S_IDLE;
            done <= last_q;
          end
        endcase
      end
    end
  end

  assign in_ready = (st == S_IDLE);
  assign cs_n     = (st == S_IDLE) || (st == S_TAIL);
  assign reg_sel  = cs_n ? 1'b1 : rs_q;
  assign sclk     = !((st == S_SETUP) || (st == S_LOW));
  assign sdo      = ((st == S_LOW) || (st == S_HIGH)) ? sh[DW-1] : 1'b1;
endmodule

// File: rtl/disp_ser_tx_chk.sv
module disp_ser_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic done,
  input logic cs_n,
  input logic reg_sel,
  input logic sclk,
  input logic sdo
);
  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (cs_n && reg_sel && sclk && sdo && in_ready && !done));

  // R5
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (reg_sel && sclk && sdo));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(sdo));

  // R7
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (!sclk && sdo));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (in_ready && cs_n));
endmodule

bind disp_ser_tx disp_ser_tx_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .cs_n(cs_n), .reg_sel(reg_sel), .sclk(sclk), .sdo(sdo)
);

// File: tb/test_disp_ser_tx.sv
module test_disp_ser_tx;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_is_data = 1'b0;
  logic in_last = 1'b0;
  logic in_ready, done, cs_n, reg_sel, sclk, sdo;

  always #2 clk = ~clk;

  disp_ser_tx #(.HALF_CYC(HALF), .DW(8)) i_disp_ser_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
    .done(done), .cs_n(cs_n), .reg_sel(reg_sel), .sclk(sclk), .sdo(sdo)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [7:0] exp_b [0:599];
  bit exp_rs [0:599];
  int n_exp = 0;
  int fidx = 0;
  int n_done = 0;
  bit dbl_done = 0;
  bit aborting = 0;

  bit prev_sclk = 1, prev_cs = 1, prev_sdo = 1, prev_done = 0;
  bit in_frame = 0, have_prev = 0;
  bit bad_tim, bad_hold, bad_setup, bad_gap;
  bit rs_cap;
  logic [7:0] cap;
  int k, nrise, gap;

  always @(negedge clk) begin
    if (rst) begin
      in_frame = 0;
      prev_sclk = 1; prev_cs = 1; prev_sdo = 1; prev_done = 0;
      gap = 0; bad_gap = 0;
    end else begin
      if (prev_cs && !cs_n) begin
        if (!aborting && have_prev) chk(gap >= HALF + 1 && !bad_gap, "R6 idle gap", gap, HALF + 1);
        if (!aborting) chk(!sclk, "R7 clock low with select", sclk, 0);
        in_frame = 1; k = 0; nrise = 0; cap = '0;
        bad_tim = 0; bad_hold = 0; bad_setup = 0; rs_cap = 0;
      end else if (in_frame && !cs_n) k++;
      if (in_frame && !cs_n) begin
        if (k < HALF && !sdo) bad_setup = 1;
        if (!prev_cs && prev_sclk && sclk && sdo !== prev_sdo) bad_hold = 1;
        if (!prev_sclk && sclk) begin
          if (k != 2 * HALF * (nrise + 1)) bad_tim = 1;
          cap = {cap[6:0], sdo};
          if (nrise == 7) rs_cap = reg_sel;
          nrise++;
        end
        if (prev_sclk && !sclk && k > 0 && k != 2 * HALF * nrise + HALF) bad_tim = 1;
      end
      if (in_frame && !prev_cs && cs_n) begin
        in_frame = 0;
        if (!aborting) begin
          chk(nrise == 8, "R2 bit count", nrise, 8);
          chk(cap == exp_b[fidx], "R2 byte value", cap, exp_b[fidx]);
          chk(rs_cap == exp_rs[fidx], "R4 register select", rs_cap, exp_rs[fidx]);
          chk(!bad_hold, "R3 data hold", bad_hold, 0);
          chk(!bad_setup, "R7 setup data high", bad_setup, 0);
          chk(!bad_tim && k == 17 * HALF - 1, "R8 edge timing", k, 17 * HALF - 1);
          fidx++;
          have_prev = 1;
        end
        gap = 0; bad_gap = 0;
      end
      if (cs_n) begin
        gap++;
        if (!(sclk && sdo && reg_sel)) bad_gap = 1;
      end
      if (done) begin
        n_done++;
        if (prev_done) dbl_done = 1;
        chk(in_ready && cs_n, "R10 done with idle", in_ready, 1);
      end
      prev_done = done;
      prev_sclk = sclk; prev_cs = cs_n; prev_sdo = sdo;
    end
  end

  task automatic send(input logic [7:0] b, input bit is_data, input bit last);
    @(negedge clk);
    in_byte = b; in_is_data = is_data; in_last = last; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_b[n_exp] = b;
    exp_rs[n_exp] = is_data;
    n_exp++;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R9 busy after accept", in_ready, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    chk(cs_n && reg_sel && sclk && sdo, "R1 idle lines",
        {cs_n, reg_sel, sclk, sdo}, 15);
    chk(in_ready && !done, "R1 ready no done", {in_ready, done}, 2);
    rst = 1'b0;

    for (int b = 0; b < 256; b++) send(8'(b), 1'b0, 1'b0);
    for (int b = 0; b < 256; b++) send(8'(b), 1'b1, (b % 8) == 7);
    repeat (60) @(negedge clk);
    chk(fidx == 512, "R2 frames seen", fidx, 512);
    chk(n_done == 256 + 32, "R10 done count", n_done, 288);
    chk(!dbl_done, "R10 single-cycle done", dbl_done, 0);

    aborting = 1;
    @(negedge clk);
    in_byte = 8'hA5; in_is_data = 1'b1; in_last = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(!cs_n, "R11 transfer under way", cs_n, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(cs_n && reg_sel && sclk && sdo, "R11 idle after reset",
        {cs_n, reg_sel, sclk, sdo}, 15);
    chk(in_ready && !done, "R11 ready after reset", {in_ready, done}, 2);
    d0 = n_done;
    repeat (60) @(negedge clk);
    chk(n_done == d0, "R11 no done after abort", n_done, d0);
    chk(cs_n && sdo, "R11 lines stay idle", {cs_n, sdo}, 3);

    finish_run();
  end
endmodule